// File: doc/BRIEF.md
# Multichannel ADC Register Engine

This block is the register front end of an analog-to-digital converter engine. It sits on a simple 32-bit memory-mapped bus and holds several kinds of register. There is an engine control register, plus interrupt, detect and clock control registers. Packed sample registers each carry two 10-bit channels, and each channel has its own limit and hysteresis register. An interrupt-source register and a trim register complete the set. Software reaches every register through a one-cycle request, and read data returns one cycle later.

No converter is attached. Each read of a sample register acts as a stand-in acquisition: the value before the update is returned, then the low channel advances by 5 and the high channel by 7, both modulo 1024. Both updated channels are then tested against their limit windows. A channel outside its window sets an interrupt bit for that sample register and drives the interrupt output.

The channel count is a parameter (8 or 16). In the 8-channel build the upper half of the sample, limit and hysteresis space reads as zero and ignores writes.

Top module: `adc_reg_engine`

## Requirements
- R1: After reset, engine control and interrupt control read 0, detect control (0x08) and clock control (0x0C) read 0x0000000F, limit registers read 0, and irq_o is low.
- R2: A read request (req_i=1, we_i=0) is answered one cycle later: rvalid_o is high for exactly that cycle and rdata_o holds the result.
- R3: A read of sample register k (offset 0x10+4k) returns the stored value, with the low channel in [9:0] and the high channel in [25:16]. The stored value then becomes low+5 and high+7.
- R4: Write masks are as follows. Sample and limit registers keep bits [25:16] and [9:0]. Hysteresis registers (0x70+4i) keep those bits plus bit 31. Interrupt source (0xC0) keeps [15:0] and trim (0xC4) keeps [3:0]. Detect and clock control keep all 32 bits.
- R5: A write to engine control (0x00) stores the written bit 0 into bit 8, whatever was written to bit 8. Bit 5 always reads 0, and all other bits are stored as written.
- R6: After a sample update, channel 2k is compared with limit register 2k (0x30+8k) and channel 2k+1 with limit register 2k+1. Each limit register holds the lower limit in [9:0] and the upper limit in [25:16]. If either channel is below its lower limit or above its upper limit, bit k of interrupt control (0x04) is set and irq_o goes high.
- R7: A sample update with both channels inside their windows, limits included, leaves interrupt control unchanged.
- R8: irq_o is high exactly while any of bits [7:0] of interrupt control is set. A write to 0x04 replaces the register, so writing zeros clears the interrupt. Bits above 7 do not drive irq_o.
- R9: A read at a sample address with bit 1 set returns the upper 16 bits of the stored value in rdata_o[15:0], with zeros above. It still advances the samples and runs the window check.
- R10: Reads of unmapped offsets (0xB0–0xBC, 0xC8–0xFC) return 0, and writes to them change no register.
- R11: With NUM_CH=8, the sample registers at 0x20–0x2C and the limit and hysteresis registers for channels 8–15 read as 0. Writes to them are ignored, and reads of them neither update samples nor set interrupt bits.
- R12: Sample arithmetic wraps at 10 bits: a low channel of 1022 becomes 3, and a high channel of 1020 becomes 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request strobe, one cycle per transaction |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset within the 0x100 window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| irq_o | output | 1 | Out-of-window interrupt |

## Verification
The bench builds two copies of the engine side by side: one with NUM_CH=16 and one with NUM_CH=8. The 16-channel copy covers the full sample and limit space, including pair 7 and interrupt bit 7, the 10-bit wrap, and a breach on either channel of a pair. The 8-channel copy shows that the upper half of the map reads zero, keeps nothing and triggers no sample side effect. The same offsets on the other copy behave normally.

// File: rtl/adc_reg_pkg.sv
package adc_reg_pkg;
  localparam int SMP_W    = 10;
  localparam int MAX_PAIR = 8;
  localparam int MAX_CH   = 16;
  localparam logic [SMP_W-1:0] LO_STEP = 10'd5;
  localparam logic [SMP_W-1:0] HI_STEP = 10'd7;

  // word index = addr[7:2]
  localparam logic [5:0] WI_CTRL  = 6'd0;
  localparam logic [5:0] WI_IRQ   = 6'd1;
  localparam logic [5:0] WI_DET   = 6'd2;
  localparam logic [5:0] WI_CLK   = 6'd3;
  localparam logic [5:0] WI_SMP0  = 6'd4;
  localparam logic [5:0] WI_LIM0  = 6'd12;
  localparam logic [5:0] WI_HYS0  = 6'd28;
  localparam logic [5:0] WI_ISRC  = 6'd48;
  localparam logic [5:0] WI_TRIM  = 6'd49;

  localparam logic [31:0] PAIR_MASK = 32'h03FF_03FF;
  localparam logic [31:0] HYS_MASK  = 32'h83FF_03FF;
  localparam logic [31:0] ISRC_MASK = 32'h0000_FFFF;
  localparam logic [31:0] TRIM_MASK = 32'h0000_000F;
  localparam logic [31:0] CTL_RST   = 32'h0000_000F;

  typedef struct packed {
    logic [SMP_W-1:0] hi;
    logic [SMP_W-1:0] lo;
  } pair_t;

  function automatic logic [31:0] pair_to_word(pair_t p);
    return {6'b0, p.hi, 6'b0, p.lo};
  endfunction

  function automatic pair_t word_to_pair(logic [31:0] w);
    pair_t p;
    p.hi = w[25:16];
    p.lo = w[9:0];
    return p;
  endfunction
endpackage

// File: rtl/adc_pair_step.sv
module adc_pair_step
  import adc_reg_pkg::*;
(
  input  pair_t cur_i,
  input  pair_t lim_lo_i,  // window of low channel: lo=min, hi=max
  input  pair_t lim_hi_i,  // window of high channel
  output pair_t nxt_o,
  output logic  breach_o
);
  logic out_lo, out_hi;

  always_comb begin
    nxt_o.lo = cur_i.lo + LO_STEP;
    nxt_o.hi = cur_i.hi + HI_STEP;
    out_lo   = (nxt_o.lo < lim_lo_i.lo) || (nxt_o.lo > lim_lo_i.hi);
    out_hi   = (nxt_o.hi < lim_hi_i.lo) || (nxt_o.hi > lim_hi_i.hi);
    breach_o = out_lo || out_hi;
  end
endmodule

// File: rtl/adc_sample_bank.sv
module adc_sample_bank
  import adc_reg_pkg::*;
#(
  parameter int NUM_PAIRS = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  upd_en_i,
  input  logic [2:0]            upd_idx_i,
  input  pair_t                 upd_val_i,
  output pair_t [NUM_PAIRS-1:0] pairs_o
);
  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  pairs_o[g] <= '0;
      else if (upd_en_i && upd_idx_i == 3'(g))      pairs_o[g] <= upd_val_i;
    end
  end
endmodule

// File: rtl/adc_word_bank.sv
module adc_word_bank #(
  parameter int          DEPTH = 16,
  parameter logic [31:0] MASK  = 32'hFFFF_FFFF
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [3:0]             wr_idx_i,
  input  logic [31:0]            wr_data_i,
  output logic [DEPTH-1:0][31:0] regs_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs_o[g] <= '0;
      else if (wr_en_i && wr_idx_i == 4'(g))     regs_o[g] <= wr_data_i & MASK;
    end
  end
endmodule

// File: rtl/adc_reg_engine.sv
module adc_reg_engine
  import adc_reg_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        rvalid_o,
  output logic        irq_o
);
  localparam int NUM_PAIRS = NUM_CH / 2;

  logic [5:0]  widx, smp_off, lim_off, hys_off;
  logic        rd_fire, wr_fire;
  logic        is_smp, is_lim, is_hys;
  pair_t       sel_pair, win_lo, win_hi, nxt_pair, upd_val;
  logic        breach;
  logic [31:0] lim_sel, hys_sel, rd_word, ctrl_wr;
  logic [31:0] ctrl_q, irq_q, det_q, clk_q, isrc_q, trim_q;
  pair_t [NUM_PAIRS-1:0]    pairs;
  logic  [NUM_CH-1:0][31:0] lim_regs, hys_regs;
  logic  unused_bits;

  assign unused_bits = addr_i[0];
  assign widx    = addr_i[7:2];
  assign rd_fire = req_i & ~we_i;
  assign wr_fire = req_i & we_i;
  assign smp_off = widx - WI_SMP0;
  assign lim_off = widx - WI_LIM0;
  assign hys_off = widx - WI_HYS0;

  // offsets below a base wrap high, so an index match implies a hit
  always_comb begin
    is_smp   = 1'b0;
    sel_pair = '0;
    win_lo   = '0;
    win_hi   = '0;
    for (int k = 0; k < NUM_PAIRS; k++) begin
      if (smp_off == 6'(k)) begin
        is_smp   = 1'b1;
        sel_pair = pairs[k];
        win_lo   = word_to_pair(lim_regs[2*k]);
        win_hi   = word_to_pair(lim_regs[2*k+1]);
      end
    end
    is_lim  = 1'b0;
    is_hys  = 1'b0;
    lim_sel = '0;
    hys_sel = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (lim_off == 6'(i)) begin
        is_lim  = 1'b1;
        lim_sel = lim_regs[i];
      end
      if (hys_off == 6'(i)) begin
        is_hys  = 1'b1;
        hys_sel = hys_regs[i];
      end
    end
  end

  adc_pair_step u_step (
    .cur_i    (sel_pair),
    .lim_lo_i (win_lo),
    .lim_hi_i (win_hi),
    .nxt_o    (nxt_pair),
    .breach_o (breach)
  );

  assign upd_val = we_i ? word_to_pair(wdata_i) : nxt_pair;

  adc_sample_bank #(.NUM_PAIRS(NUM_PAIRS)) u_smp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_en_i  (req_i & is_smp),
    .upd_idx_i (smp_off[2:0]),
    .upd_val_i (upd_val),
    .pairs_o   (pairs)
  );

  adc_word_bank #(.DEPTH(NUM_CH), .MASK(PAIR_MASK)) u_lim (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_fire & is_lim),
    .wr_idx_i  (lim_off[3:0]),
    .wr_data_i (wdata_i),
    .regs_o    (lim_regs)
  );

  adc_word_bank #(.DEPTH(NUM_CH), .MASK(HYS_MASK)) u_hys (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_fire & is_hys),
    .wr_idx_i  (hys_off[3:0]),
    .wr_data_i (wdata_i),
    .regs_o    (hys_regs)
  );

  always_comb begin
    ctrl_wr    = wdata_i;
    ctrl_wr[8] = wdata_i[0];
    ctrl_wr[5] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      irq_q  <= '0;
      det_q  <= CTL_RST;
      clk_q  <= CTL_RST;
      isrc_q <= '0;
      trim_q <= '0;
    end else if (wr_fire) begin
      case (widx)
        WI_CTRL: ctrl_q <= ctrl_wr;
        WI_IRQ:  irq_q  <= wdata_i;
        WI_DET:  det_q  <= wdata_i;
        WI_CLK:  clk_q  <= wdata_i;
        WI_ISRC: isrc_q <= wdata_i & ISRC_MASK;
        WI_TRIM: trim_q <= wdata_i & TRIM_MASK;
        default: ;
      endcase
    end else if (rd_fire && is_smp && breach) begin
      irq_q[smp_off[2:0]] <= 1'b1;
    end
  end

  always_comb begin
    rd_word = '0;
    if (is_smp)      rd_word = pair_to_word(sel_pair);
    else if (is_lim) rd_word = lim_sel;
    else if (is_hys) rd_word = hys_sel;
    else begin
      case (widx)
        WI_CTRL: rd_word = ctrl_q;
        WI_IRQ:  rd_word = irq_q;
        WI_DET:  rd_word = det_q;
        WI_CLK:  rd_word = clk_q;
        WI_ISRC: rd_word = isrc_q;
        WI_TRIM: rd_word = trim_q;
        default: rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_fire;
      if (rd_fire) rdata_o <= addr_i[1] ? {16'b0, rd_word[31:16]} : rd_word;
    end
  end

  assign irq_o = |irq_q[7:0];
endmodule

// File: rtl/adc_reg_engine_chk.sv
module adc_reg_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [7:0]  addr_i,
  input logic [31:0] rdata_o,
  input logic        rvalid_o,
  input logic        irq_o
);
  logic rd, unmapped;
  assign rd       = req_i && !we_i;
  assign unmapped = (addr_i[7:2] >= 6'd50) ||
                    (addr_i[7:2] >= 6'd44 && addr_i[7:2] < 6'd48);

  a_r2_rvalid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rvalid_o);
  a_r2_rvalid_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> !rvalid_o);
  a_r5_ctrl_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == 8'h00) |=> (!rdata_o[5] && rdata_o[8] == rdata_o[0]));
  a_r4_trim_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == 8'hC4) |=> (rdata_o[31:4] == 28'h0));
  a_r10_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && unmapped) |=> (rdata_o == 32'h0));
  a_r8_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(req_i && we_i && addr_i[7:2] == 6'd1)) |=> irq_o);
  a_r6_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(req_i));
endmodule

bind adc_reg_engine adc_reg_engine_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .rvalid_o (rvalid_o),
  .irq_o    (irq_o)
);

// File: tb/tb_adc_reg_engine.sv
module tb_adc_reg_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_a = 1'b0, req_b = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        rvalid_a, rvalid_b, irq_a, irq_b;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_reg_engine #(.NUM_CH(16)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_a), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_a), .rvalid_o(rvalid_a), .irq_o(irq_a));

  adc_reg_engine #(.NUM_CH(8)) dut_n8 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_b), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_b), .rvalid_o(rvalid_b), .irq_o(irq_b));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(bit n8, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    if (n8) req_b = 1'b1; else req_a = 1'b1;
    @(negedge clk);
    req_a = 1'b0; req_b = 1'b0; we = 1'b0;
  endtask

  task automatic rd(bit n8, logic [7:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    addr = a; we = 1'b0;
    if (n8) req_b = 1'b1; else req_a = 1'b1;
    @(negedge clk);
    req_a = 1'b0; req_b = 1'b0;
    d = n8 ? rdata_b : rdata_a;
    v = n8 ? rvalid_b : rvalid_a;
  endtask

  task automatic rd_chk(bit n8, logic [7:0] a, logic [31:0] exp, string tag);
    logic [31:0] d; logic v;
    rd(n8, a, d, v);
    check(tag, d, exp);
  endtask

  task automatic t_reset;
    logic [31:0] d; logic v;
    check("R1 irq_o", {31'b0, irq_a}, 32'h0);
    rd(0, 8'h00, d, v);
    check("R1 ctrl", d, 32'h0);
    check("R2 rvalid high", {31'b0, v}, 32'h1);
    @(negedge clk);
    check("R2 rvalid drops", {31'b0, rvalid_a}, 32'h0);
    rd_chk(0, 8'h04, 32'h0, "R1 irqctl");
    rd_chk(0, 8'h08, 32'hF, "R1 detect");
    rd_chk(0, 8'h0C, 32'hF, "R1 clock");
    rd_chk(0, 8'h30, 32'h0, "R1 limit0");
  endtask

  task automatic t_ctrl;
    wr(0, 8'h00, 32'h0003_002F);
    rd_chk(0, 8'h00, 32'h0003_010F, "R5 en mirrored, bit5 zero");
    wr(0, 8'h00, 32'h0000_0100);
    rd_chk(0, 8'h00, 32'h0, "R5 written bit8 ignored");
  endtask

  task automatic t_masks;
    wr(0, 8'h34, 32'hFFFF_FFFF);
    rd_chk(0, 8'h34, 32'h03FF_03FF, "R4 limit mask");
    wr(0, 8'h70, 32'hFFFF_FFFF);
    rd_chk(0, 8'h70, 32'h83FF_03FF, "R4 hyst mask");
    wr(0, 8'hC0, 32'hFFFF_FFFF);
    rd_chk(0, 8'hC0, 32'h0000_FFFF, "R4 isrc mask");
    wr(0, 8'hC4, 32'hFFFF_FFFF);
    rd_chk(0, 8'hC4, 32'h0000_000F, "R4 trim mask");
    wr(0, 8'h08, 32'h1234_5678);
    rd_chk(0, 8'h08, 32'h1234_5678, "R4 detect full");
    wr(0, 8'h14, 32'hFFFF_FFFF);
    rd_chk(0, 8'h14, 32'h03FF_03FF, "R4 sample mask");
    // limits 2,3 are zero, so the update breaches
    rd_chk(0, 8'h04, 32'h0000_0002, "R6 bit1 set");
    check("R6 irq_o", {31'b0, irq_a}, 32'h1);
    wr(0, 8'h04, 32'h0);
    check("R8 cleared", {31'b0, irq_a}, 32'h0);
  endtask

  task automatic t_sample;
    wr(0, 8'h40, 32'h03FF_0000);
    wr(0, 8'h44, 32'h03FF_0000);
    wr(0, 8'h18, 32'h0064_00C8);
    rd_chk(0, 8'h18, 32'h0064_00C8, "R3 returns stored");
    rd_chk(0, 8'h18, 32'h006B_00CD, "R3 advanced by 5/7");
    wr(0, 8'h18, 32'h03FC_03FE);
    rd_chk(0, 8'h18, 32'h03FC_03FE, "R12 pre-wrap");
    rd_chk(0, 8'h18, 32'h0003_0003, "R12 wrap");
    check("R7 in window no irq", {31'b0, irq_a}, 32'h0);
  endtask

  task automatic t_window;
    wr(0, 8'h48, 32'h0032_000A);
    wr(0, 8'h4C, 32'h03FF_000A);
    wr(0, 8'h1C, 32'h0064_0014);
    rd_chk(0, 8'h1C, 32'h0064_0014, "R3 pair3");
    rd_chk(0, 8'h04, 32'h0, "R7 inside window");
    wr(0, 8'h1C, 32'h0064_0030);
    rd_chk(0, 8'h1C, 32'h0064_0030, "R3 pair3 b");
    rd_chk(0, 8'h04, 32'h0000_0008, "R6 low channel above max");
    check("R6 irq_o low ch", {31'b0, irq_a}, 32'h1);
    wr(0, 8'h04, 32'h0);
    wr(0, 8'h1C, 32'h0000_0014);
    rd_chk(0, 8'h1C, 32'h0000_0014, "R3 pair3 c");
    rd_chk(0, 8'h04, 32'h0000_0008, "R6 high channel below min");
    wr(0, 8'h04, 32'h0);
    check("R8 clear by write", {31'b0, irq_a}, 32'h0);
    wr(0, 8'h04, 32'h0000_0100);
    check("R8 bit8 no irq", {31'b0, irq_a}, 32'h0);
    rd_chk(0, 8'h04, 32'h0000_0100, "R8 readback");
    wr(0, 8'h04, 32'h0000_0040);
    check("R8 bit6 irq", {31'b0, irq_a}, 32'h1);
    wr(0, 8'h04, 32'h0);
    rd_chk(0, 8'h2C, 32'h0, "R3 pair7");
    rd_chk(0, 8'h04, 32'h0000_0080, "R6 bit7 pair7");
    wr(0, 8'h04, 32'h0);
  endtask

  task automatic t_half;
    wr(0, 8'h10, 32'h012C_0028);
    rd_chk(0, 8'h12, 32'h0000_012C, "R9 upper half");
    rd_chk(0, 8'h10, 32'h0133_002D, "R9 half read advanced");
    wr(0, 8'h04, 32'h0);
  endtask

  task automatic t_unmapped;
    wr(0, 8'hB0, 32'hDEAD_BEEF);
    rd_chk(0, 8'hB0, 32'h0, "R10 gap read");
    wr(0, 8'hC8, 32'hDEAD_BEEF);
    rd_chk(0, 8'hC8, 32'h0, "R10 tail read");
    rd_chk(0, 8'h08, 32'h1234_5678, "R10 no alias write");
    check("R10 irq untouched", {31'b0, irq_a}, 32'h0);
  endtask

  task automatic t_n8;
    wr(1, 8'h20, 32'h0001_0001);
    rd_chk(1, 8'h20, 32'h0, "R11 sample4 invalid");
    check("R11 no side effect", {31'b0, irq_b}, 32'h0);
    wr(1, 8'h50, 32'h03FF_03FF);
    rd_chk(1, 8'h50, 32'h0, "R11 limit8 invalid");
    wr(1, 8'h90, 32'hFFFF_FFFF);
    rd_chk(1, 8'h90, 32'h0, "R11 hyst8 invalid");
    rd_chk(1, 8'h04, 32'h0, "R11 irq reg untouched");
    wr(1, 8'h1C, 32'h0002_0001);
    rd_chk(1, 8'h1C, 32'h0002_0001, "R11 sample3 valid");
    check("R11 valid read breach", {31'b0, irq_b}, 32'h1);
    wr(0, 8'h20, 32'h0001_0001);
    rd_chk(0, 8'h20, 32'h0001_0001, "R11 16ch sample4 valid");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_masks();
    t_sample();
    t_window();
    t_half();
    t_unmapped();
    t_n8();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule